// File: doc/BRIEF.md
# Write-and-Invalidate Burst Command Selector

This block sits in the write path of a PCI bus initiator, between the DMA engines and the bus master state machine. It accepts one write request at a time: a starting DWORD address, a length in DWORDs, a tag naming the engine that issued it, and the current 8-bit cache-line-size setting. It then emits burst descriptors one after another, each made of a PCI bus command, a DWORD address and a DWORD count. The descriptor stream uses a valid/ready handshake.

When the cache-line-size setting names a supported line of 4, 8 or 16 DWORDs, the request is cut at every line boundary. A chunk that covers one whole aligned line and that came from the general-purpose PCI DMA engine is issued as memory-write-and-invalidate. Every other chunk is issued as plain memory write: a head before the first boundary, a partial tail, or any chunk from another engine. Any other setting turns line handling off, and the whole request goes out as one plain memory write.

The line setting and the source tag are captured when the request is accepted. Later changes to the setting do not reach a request that is already being split.

Top module: `wrBurstCmdSel`

## Requirements
- R1: After reset, reqReady is 1 and burstValid is 0.
- R2: With lineSizeCfg = 0x04 and source 2'b00 (PCI DMA), every whole 4-DWORD chunk aligned to a 4-DWORD address boundary is issued with burstCmd = 4'hF (memory-write-and-invalidate) and burstLen = 4.
- R3: lineSizeCfg = 0x08 gives 8-DWORD lines and 0x10 gives 16-DWORD lines. With source 2'b00, a whole aligned line is issued with burstCmd = 4'hF and burstLen equal to the line size.
- R4: Any lineSizeCfg value other than 0x04, 0x08 or 0x10 makes the request come out as exactly one descriptor: burstCmd = 4'h7 (memory write), the request's address, and its full length.
- R5: Requests tagged 2'b01 (image-coprocessor DMA), 2'b10 (CPU write) or 2'b11 always use burstCmd = 4'h7. They are still cut at line boundaries when the line setting is supported.
- R6: With a supported line setting, a head before the first line boundary and a partial tail after the last boundary are each issued as their own descriptor with burstCmd = 4'h7.
- R7: With a supported line setting, no descriptor crosses a line boundary. The descriptors of one request are non-empty, follow each other in address order without gaps, and their lengths add up to the request length.
- R8: The line setting is sampled when the request is accepted. Changing lineSizeCfg while the request is being split does not change its descriptors.
- R9: A request of length 0 is accepted, produces no descriptor, and leaves reqReady at 1 in the next cycle.
- R10: While burstValid is 1 and burstReady is 0, burstValid stays 1 and burstCmd, burstAddr and burstLen stay unchanged on the next cycle.
- R11: From the cycle after a non-empty request is accepted until its last descriptor is taken, reqReady is 0. reqReady is never 1 while burstValid is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A write request is offered |
| reqReady | output | 1 | The block can accept a request |
| reqAddr | input | ADDR_W (30) | Starting DWORD address of the request |
| reqLen | input | LEN_W (12) | Request length in DWORDs |
| reqSrc | input | 2 | Source tag: 00 PCI DMA, 01 coprocessor DMA, 10 CPU write, 11 other |
| lineSizeCfg | input | 8 | Programmed cache-line-size value |
| burstValid | output | 1 | A burst descriptor is presented |
| burstReady | input | 1 | The consumer takes the descriptor |
| burstCmd | output | 4 | PCI command: 4'h7 memory write, 4'hF memory-write-and-invalidate |
| burstAddr | output | ADDR_W (30) | DWORD address of the burst |
| burstLen | output | LEN_W (12) | DWORD count of the burst |

## Verification
The bench sends requests that start in the middle of a line and end in the middle of another. A design that ignores the head or the tail would mark those partial chunks for invalidation, or would let a burst run past a boundary. It also offers unsupported line values such as 0x00 and 0x20, where a wrong design would split the request or use the invalidate command, and it tags requests with each engine that is not allowed to invalidate. It changes the line setting in the middle of a request and sends zero-length requests. A design that reads the live setting would change its chunk sizes, and a wrong zero-length path would emit an empty descriptor or hang. Stalls on the descriptor port check that a held descriptor does not move.

// File: rtl/wrBurstPkg.sv
package wrBurstPkg;

  localparam logic [3:0] CMD_MEM_WR     = 4'h7;
  localparam logic [3:0] CMD_MEM_WR_INV = 4'hF;

  typedef enum logic [1:0] {
    SRC_PCI_DMA = 2'b00,
    SRC_COP_DMA = 2'b01,
    SRC_CPU     = 2'b10,
    SRC_OTHER   = 2'b11
  } srcTag_t;

  typedef struct packed {
    logic load;
    logic step;
  } ctrlStrobe_t;

  // Line size in DWORDs for a cache-line-size value; 0 = line handling off.
  function automatic logic [4:0] decodeLineDw(input logic [7:0] cfg);
    case (cfg)
      8'h04:   decodeLineDw = 5'd4;
      8'h08:   decodeLineDw = 5'd8;
      8'h10:   decodeLineDw = 5'd16;
      default: decodeLineDw = 5'd0;
    endcase
  endfunction

endpackage

// File: rtl/wrBurstCtrl.sv
module wrBurstCtrl
  import wrBurstPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqLenZero,
  input  logic        burstReady,
  input  logic        lastChunk,
  output logic        reqReady,
  output logic        burstValid,
  output ctrlStrobe_t strobe
);

  typedef enum logic {ST_IDLE, ST_BUSY} ctrlState_t;
  ctrlState_t state, stateNext;

  always_comb begin
    reqReady    = (state == ST_IDLE);
    burstValid  = (state == ST_BUSY);
    strobe.load = reqValid && reqReady && !reqLenZero;
    strobe.step = burstValid && burstReady;
    stateNext   = state;
    case (state)
      ST_IDLE: if (strobe.load) stateNext = ST_BUSY;
      ST_BUSY: if (strobe.step && lastChunk) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

endmodule

// File: rtl/wrBurstDatapath.sv
module wrBurstDatapath
  import wrBurstPkg::*;
#(
  parameter int ADDR_W = 30,
  parameter int LEN_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic [1:0]        reqSrc,
  input  logic [7:0]        lineSizeCfg,
  output logic              lastChunk,
  output logic [3:0]        burstCmd,
  output logic [ADDR_W-1:0] burstAddr,
  output logic [LEN_W-1:0]  burstLen
);

  logic [ADDR_W-1:0] curAddr;
  logic [LEN_W-1:0]  remLen;
  logic [7:0]        cfgHeld;
  logic [1:0]        srcHeld;

  logic [LEN_W-1:0]  lineDw;
  logic              lineOn;
  logic [LEN_W-1:0]  lineOffset;
  logic [LEN_W-1:0]  toBoundary;
  logic [LEN_W-1:0]  chunkLen;
  logic              wholeLine;

  always_comb begin
    lineDw     = LEN_W'(decodeLineDw(cfgHeld));
    lineOn     = (lineDw != '0);
    lineOffset = curAddr[LEN_W-1:0] & (lineDw - LEN_W'(1));
    toBoundary = lineDw - lineOffset;
    if (lineOn && (remLen > toBoundary)) chunkLen = toBoundary;
    else                                  chunkLen = remLen;
    wholeLine  = lineOn && (lineOffset == '0) && (chunkLen == lineDw);
    lastChunk  = (chunkLen == remLen);
    burstCmd   = (wholeLine && (srcHeld == SRC_PCI_DMA)) ? CMD_MEM_WR_INV : CMD_MEM_WR;
    burstAddr  = curAddr;
    burstLen   = chunkLen;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr <= '0;
      remLen  <= '0;
      cfgHeld <= '0;
      srcHeld <= '0;
    end else if (strobe.load) begin
      curAddr <= reqAddr;
      remLen  <= reqLen;
      cfgHeld <= lineSizeCfg;
      srcHeld <= reqSrc;
    end else if (strobe.step) begin
      curAddr <= curAddr + ADDR_W'(chunkLen);
      remLen  <= remLen - chunkLen;
    end
  end

endmodule

// File: rtl/wrBurstCmdSel.sv
module wrBurstCmdSel
  import wrBurstPkg::*;
#(
  parameter int ADDR_W = 30,
  parameter int LEN_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic [1:0]        reqSrc,
  input  logic [7:0]        lineSizeCfg,
  output logic              burstValid,
  input  logic              burstReady,
  output logic [3:0]        burstCmd,
  output logic [ADDR_W-1:0] burstAddr,
  output logic [LEN_W-1:0]  burstLen
);

  ctrlStrobe_t strobe;
  logic        lastChunk;
  logic        reqLenZero;

  assign reqLenZero = (reqLen == '0);

  wrBurstCtrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqLenZero (reqLenZero),
    .burstReady (burstReady),
    .lastChunk  (lastChunk),
    .reqReady   (reqReady),
    .burstValid (burstValid),
    .strobe     (strobe)
  );

  wrBurstDatapath #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .reqAddr     (reqAddr),
    .reqLen      (reqLen),
    .reqSrc      (reqSrc),
    .lineSizeCfg (lineSizeCfg),
    .lastChunk   (lastChunk),
    .burstCmd    (burstCmd),
    .burstAddr   (burstAddr),
    .burstLen    (burstLen)
  );

endmodule

// File: rtl/wrBurstCmdSelChk.sv
module wrBurstCmdSelChk
  import wrBurstPkg::*;
#(
  parameter int ADDR_W = 30,
  parameter int LEN_W  = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [1:0]        reqSrc,
  input logic [7:0]        lineSizeCfg,
  input logic              burstValid,
  input logic              burstReady,
  input logic [3:0]        burstCmd,
  input logic [ADDR_W-1:0] burstAddr,
  input logic [LEN_W-1:0]  burstLen
);

  logic [1:0] srcSeen;
  logic [7:0] cfgSeen;
  logic [LEN_W-1:0] lineSeen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcSeen <= '0;
      cfgSeen <= '0;
    end else if (reqValid && reqReady) begin
      srcSeen <= reqSrc;
      cfgSeen <= lineSizeCfg;
    end
  end

  assign lineSeen = LEN_W'(decodeLineDw(cfgSeen));

  assert_ready_excl_R11: assert property (@(posedge clk) disable iff (!rstN)
    burstValid |-> !reqReady);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (burstValid && !burstReady) |=> (burstValid && $stable(burstCmd)
      && $stable(burstAddr) && $stable(burstLen)));

  assert_inval_src_R5: assert property (@(posedge clk) disable iff (!rstN)
    (burstValid && burstCmd == CMD_MEM_WR_INV) |-> (srcSeen == SRC_PCI_DMA));

  assert_inval_shape_R2: assert property (@(posedge clk) disable iff (!rstN)
    (burstValid && burstCmd == CMD_MEM_WR_INV) |-> (lineSeen != '0
      && burstLen == lineSeen
      && (burstAddr[LEN_W-1:0] & (lineSeen - LEN_W'(1))) == '0));

  assert_off_plain_R4: assert property (@(posedge clk) disable iff (!rstN)
    (burstValid && lineSeen == '0) |-> (burstCmd == CMD_MEM_WR));

  assert_nonempty_R7: assert property (@(posedge clk) disable iff (!rstN)
    burstValid |-> (burstLen != '0));

endmodule

bind wrBurstCmdSel wrBurstCmdSelChk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .reqValid    (reqValid),
  .reqReady    (reqReady),
  .reqSrc      (reqSrc),
  .lineSizeCfg (lineSizeCfg),
  .burstValid  (burstValid),
  .burstReady  (burstReady),
  .burstCmd    (burstCmd),
  .burstAddr   (burstAddr),
  .burstLen    (burstLen)
);

// File: tb/wrBurstCmdSel_bench.sv
module wrBurstCmdSel_bench;

  localparam int ADDR_W = 30;
  localparam int LEN_W  = 12;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic              reqReady;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [LEN_W-1:0]  reqLen = '0;
  logic [1:0]        reqSrc = '0;
  logic [7:0]        lineSizeCfg = '0;
  logic              burstValid;
  logic              burstReady;
  logic [3:0]        burstCmd;
  logic [ADDR_W-1:0] burstAddr;
  logic [LEN_W-1:0]  burstLen;

  int testCnt = 0;
  int failCnt = 0;
  int cycleCnt = 0;
  logic stallOn = 1'b0;
  logic [1:0] readyCnt = '0;

  logic [3:0]        expCmdQ[$];
  logic [ADDR_W-1:0] expAddrQ[$];
  logic [LEN_W-1:0]  expLenQ[$];
  string             expTagQ[$];

  always #10 clk = ~clk;

  wrBurstCmdSel #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_wrBurstCmdSel (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqLen(reqLen), .reqSrc(reqSrc), .lineSizeCfg(lineSizeCfg),
    .burstValid(burstValid), .burstReady(burstReady), .burstCmd(burstCmd),
    .burstAddr(burstAddr), .burstLen(burstLen)
  );

  always @(posedge clk) readyCnt <= readyCnt + 2'd1;
  assign burstReady = !stallOn || (readyCnt == 2'd3);

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
  endtask

  always @(posedge clk) begin
    cycleCnt <= cycleCnt + 1;
    if (cycleCnt > 20000) begin
      testCnt = testCnt + 1;
      failCnt = failCnt + 1;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<20000", cycleCnt);
      summary();
      $finish;
    end
  end

  // Monitor: pops expected descriptors as the design hands them over.
  logic              holdPrev = 1'b0;
  logic [3:0]        prevCmd;
  logic [ADDR_W-1:0] prevAddr;
  logic [LEN_W-1:0]  prevLen;

  always @(negedge clk) begin
    if (rstN) begin
      if (holdPrev) begin
        testCnt = testCnt + 1;
        if (!burstValid || burstCmd != prevCmd || burstAddr != prevAddr || burstLen != prevLen) begin
          failCnt = failCnt + 1;
          $display("FAIL R10 held descriptor moved: actual v=%0b cmd=%h addr=%0d len=%0d expected v=1 cmd=%h addr=%0d len=%0d",
                   burstValid, burstCmd, burstAddr, burstLen, prevCmd, prevAddr, prevLen);
        end
      end
      if (burstValid && burstReady) begin
        testCnt = testCnt + 1;
        if (expCmdQ.size() == 0) begin
          failCnt = failCnt + 1;
          $display("FAIL R7 unexpected descriptor: actual cmd=%h addr=%0d len=%0d expected none",
                   burstCmd, burstAddr, burstLen);
        end else begin
          automatic logic [3:0]        eCmd  = expCmdQ.pop_front();
          automatic logic [ADDR_W-1:0] eAddr = expAddrQ.pop_front();
          automatic logic [LEN_W-1:0]  eLen  = expLenQ.pop_front();
          automatic string             eTag  = expTagQ.pop_front();
          if (burstCmd != eCmd || burstAddr != eAddr || burstLen != eLen) begin
            failCnt = failCnt + 1;
            $display("FAIL %s descriptor: actual cmd=%h addr=%0d len=%0d expected cmd=%h addr=%0d len=%0d",
                     eTag, burstCmd, burstAddr, burstLen, eCmd, eAddr, eLen);
          end
        end
      end
      holdPrev = burstValid && !burstReady;
      prevCmd  = burstCmd;
      prevAddr = burstAddr;
      prevLen  = burstLen;
    end
  end

  // Reference model of the splitting rules, filled into the scoreboard.
  task automatic expectSplit(input int addr, input int len, input int src, input int cfg, input string tag);
    int lineDw;
    int a = addr;
    int rem = len;
    case (cfg)
      4:  lineDw = 4;
      8:  lineDw = 8;
      16: lineDw = 16;
      default: lineDw = 0;
    endcase
    while (rem > 0) begin
      int n;
      int off;
      off = (lineDw == 0) ? 0 : (a % lineDw);
      n   = (lineDw == 0) ? rem : (lineDw - off);
      if (n > rem) n = rem;
      expCmdQ.push_back((lineDw != 0 && off == 0 && n == lineDw && src == 0) ? 4'hF : 4'h7);
      expAddrQ.push_back(ADDR_W'(a));
      expLenQ.push_back(LEN_W'(n));
      expTagQ.push_back(tag);
      a   = a + n;
      rem = rem - n;
    end
  endtask

  task automatic sendReq(input int addr, input int len, input int src, input int cfg,
                         input int cfgAfter, input string tag);
    logic acc;
    expectSplit(addr, len, src, cfg, tag);
    @(posedge clk); #1;
    reqValid = 1'b1; reqAddr = ADDR_W'(addr); reqLen = LEN_W'(len);
    reqSrc = 2'(src); lineSizeCfg = 8'(cfg);
    do begin
      @(negedge clk);
      acc = reqReady;
    end while (!acc);
    @(posedge clk); #1;
    reqValid = 1'b0;
    lineSizeCfg = 8'(cfgAfter);
    @(negedge clk);
    testCnt = testCnt + 1;
    if (len == 0) begin
      if (!reqReady || burstValid) begin
        failCnt = failCnt + 1;
        $display("FAIL R9 zero-length: actual ready=%0b valid=%0b expected ready=1 valid=0", reqReady, burstValid);
      end
    end else if (reqReady) begin
      failCnt = failCnt + 1;
      $display("FAIL R11 ready while busy: actual=%0b expected=0", reqReady);
    end
    while (expCmdQ.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    @(negedge clk);
    testCnt = testCnt + 2;
    if (reqReady !== 1'b1) begin
      failCnt = failCnt + 1;
      $display("FAIL R1 reqReady after reset: actual=%b expected=1", reqReady);
    end
    if (burstValid !== 1'b0) begin
      failCnt = failCnt + 1;
      $display("FAIL R1 burstValid after reset: actual=%b expected=0", burstValid);
    end
    @(posedge clk); #1;
    rstN = 1'b1;

    sendReq(0,  8,  0, 8'h04, 8'h04, "R2");
    sendReq(3,  20, 0, 8'h08, 8'h08, "R6");
    sendReq(16, 40, 0, 8'h10, 8'h10, "R3");
    sendReq(8,  16, 0, 8'h08, 8'h08, "R3");
    sendReq(5,  30, 0, 8'h20, 8'h20, "R4");
    sendReq(0,  32, 0, 8'h00, 8'h00, "R4");
    sendReq(0,  16, 1, 8'h08, 8'h08, "R5");
    sendReq(2,  14, 2, 8'h04, 8'h04, "R5");
    sendReq(1,  2,  0, 8'h04, 8'h04, "R6");
    sendReq(4,  24, 0, 8'h04, 8'h10, "R8");
    sendReq(0,  0,  0, 8'h04, 8'h04, "R9");
    stallOn = 1'b1;
    sendReq(7,  37, 0, 8'h08, 8'h08, "R7");
    sendReq(0,  48, 0, 8'h10, 8'h03, "R8");
    stallOn = 1'b0;
    sendReq(100, 0, 0, 8'h10, 8'h10, "R9");

    summary();
    $finish;
  end

endmodule